// File: doc/BRIEF.md
# Recursive Crosswise Binary Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the exact product of `2*WIDTH` bits. The product is formed without shift-and-add. Each operand is split into a low half and a high half, and four half-width products are formed: low by low, high by low, low by high and high by high. The split repeats until it reaches a 2-by-2 leaf. In the leaf, every partial product bit comes from a two-input AND gate, and the bits of each column are summed with a half adder.

At each level of the tree, the two cross products and the bits that overlap from the outer products meet in the middle columns. A three-operand adder sums them. A parameter chooses how that adder is built:

- a carry-save stage followed by one carry-propagate adder, or
- a plain chain of adders, in which an `(N+1)`-bit sum of the cross terms keeps its carry.

The bottom half-width bits of the product come straight from the low-by-low product. The top bits are the upper half of the high-by-high product plus the carries out of the middle sum.

The product path is fully combinational. A single capture register follows it, so that timing can be measured from register to register. `WIDTH` must be a power of two from 2 to 16.

Top module: `vcMul`

## Requirements
- R1: `prod` equals the exact unsigned product `opA * opB` over all `2*WIDTH` bits, for every operand pair.
- R2: `prod` follows a change on `opA` or `opB` within the same clock cycle, with no clock edge in between.
- R3: After reset has been released, `prodQ` at each rising edge of `clk` takes the product of the operands that were present just before that edge. The latency is one cycle.
- R4: At a rising edge of `clk` while `rstN` is low, `prodQ` becomes zero whatever the operands are.
- R5: The 2-by-2 leaf (`WIDTH` = 2) gives the exact product for all 16 operand pairs: bit 0 is a0&b0, bit 1 is the XOR of the two cross ANDs, and bits 3:2 are a half-add of a1&b1 with the carry out of bit 1.
- R6: The carry-save variant and the plain variant of the middle three-operand adder (`ADD_KIND` 1 and 0) give identical products for every operand pair.
- R7: A zero operand gives a zero product. An operand of one returns the other operand, zero-extended.
- R8: The top part of the result never carries beyond `2*WIDTH` bits. For all-ones times all-ones, the product is `2^(2W) - 2^(W+1) + 1`, for example `0xFFFE0001` when W = 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the capture register |
| rstN | input | 1 | Active-low synchronous reset of the capture register |
| opA | input | WIDTH | Unsigned multiplicand |
| opB | input | WIDTH | Unsigned multiplier |
| prod | output | 2*WIDTH | Combinational product |
| prodQ | output | 2*WIDTH | Product registered one cycle later |

## Verification
The bench builds the block five times.

- `WIDTH` = 2 covers the bare leaf, exhaustively.
- `WIDTH` = 4 covers a single level of recursion, exhaustively.
- `WIDTH` = 8 is built once with the carry-save middle adder and once with the plain middle adder. Both are driven through all 65,536 operand pairs, so every carry pattern of two tree levels is reached, for either adder structure.
- `WIDTH` = 16 adds a third level. Its space is too large to sweep, so it gets random operands plus the zero, one and all-ones corners. Those corners push carries into the very top bit.

// File: rtl/vcMulPkg.sv
package vcMulPkg;

  localparam int MIN_W = 2;
  localparam int MAX_W = 16;

  // Structure of the three-operand adder that merges the middle columns
  typedef enum logic {
    ADD3_PLAIN = 1'b0,
    ADD3_CSA   = 1'b1
  } add3Kind_e;

  function automatic bit widthOk(input int w);
    return (w >= MIN_W) && (w <= MAX_W) && ((w & (w - 1)) == 0);
  endfunction

endpackage

// File: rtl/vcBase2.sv
// 2x2 leaf: AND-gate partial products summed column by column
module vcBase2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);

  logic pp00, pp10, pp01, pp11, col1Carry;

  always_comb begin
    pp00      = a[0] & b[0];
    pp10      = a[1] & b[0];
    pp01      = a[0] & b[1];
    pp11      = a[1] & b[1];
    // column 1: half add of the two crosswise terms
    p[0]      = pp00;
    p[1]      = pp10 ^ pp01;
    col1Carry = pp10 & pp01;
    // column 2: half add of the vertical top term with the incoming carry
    p[2]      = pp11 ^ col1Carry;
    p[3]      = pp11 & col1Carry;
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      a_r5_base_exact: assert (p == ({2'b00, a} * {2'b00, b}))
        else $error("leaf product mismatch a=%0d b=%0d p=%0d", a, b, p);
    end
  end

endmodule

// File: rtl/vcAdd3.sv
// Three-operand adder for the middle columns of one recursion level
module vcAdd3 #(
  parameter int                  W    = 8,
  parameter vcMulPkg::add3Kind_e KIND = vcMulPkg::ADD3_CSA
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W+1:0] sum
);

  localparam int SW = W + 2;

  generate
    if (KIND == vcMulPkg::ADD3_CSA) begin : g_csa
      logic [W-1:0] sumBits;
      logic [W-1:0] carryBits;
      always_comb begin
        sumBits   = x ^ y ^ z;
        carryBits = (x & y) | (x & z) | (y & z);
        sum       = {2'b00, sumBits} + {1'b0, carryBits, 1'b0};
      end
    end else begin : g_plain
      // (W+1)-bit cross-term sum keeps its carry, then the third operand joins
      logic [W:0] crossSum;
      always_comb begin
        crossSum = {1'b0, x} + {1'b0, y};
        sum      = {1'b0, crossSum} + {2'b00, z};
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown({x, y, z})) begin
      a_r6_sum_exact: assert (sum == (SW'(x) + SW'(y) + SW'(z)))
        else $error("middle adder mismatch x=%0h y=%0h z=%0h sum=%0h", x, y, z, sum);
    end
  end

endmodule

// File: rtl/vcMulNode.sv
// One recursion level: four half-width products merged by fixed adders
module vcMulNode #(
  parameter int                  W    = 8,
  parameter vcMulPkg::add3Kind_e KIND = vcMulPkg::ADD3_CSA
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);

  generate
    if (W == 2) begin : g_leaf
      vcBase2 u_leaf (
        .a(a),
        .b(b),
        .p(p)
      );
    end else begin : g_split
      localparam int H = W / 2;

      logic [W-1:0] pLL, pHL, pLH, pHH;
      logic [W+1:0] midSum;
      logic [H:0]   topSum;

      vcMulNode #(.W(H), .KIND(KIND)) u_ll (
        .a(a[H-1:0]), .b(b[H-1:0]), .p(pLL)
      );
      vcMulNode #(.W(H), .KIND(KIND)) u_hl (
        .a(a[W-1:H]), .b(b[H-1:0]), .p(pHL)
      );
      vcMulNode #(.W(H), .KIND(KIND)) u_lh (
        .a(a[H-1:0]), .b(b[W-1:H]), .p(pLH)
      );
      vcMulNode #(.W(H), .KIND(KIND)) u_hh (
        .a(a[W-1:H]), .b(b[W-1:H]), .p(pHH)
      );

      // Middle columns: both cross terms plus the overlapping outer halves
      vcAdd3 #(.W(W), .KIND(KIND)) u_mid (
        .x(pHL),
        .y(pLH),
        .z({pHH[H-1:0], pLL[W-1:H]}),
        .sum(midSum)
      );

      assign topSum = {1'b0, pHH[W-1:H]} + {{(H-1){1'b0}}, midSum[W+1:W]};
      assign p      = {topSum[H-1:0], midSum[W-1:0], pLL[H-1:0]};

      always_comb begin
        if (!$isunknown(topSum)) begin
          a_r8_no_overflow: assert (topSum[H] == 1'b0)
            else $error("carry left the top of a %0d-bit product", 2 * W);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vcMul.sv
module vcMul #(
  parameter int                  WIDTH    = 8,
  parameter vcMulPkg::add3Kind_e ADD_KIND = vcMulPkg::ADD3_CSA
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] prod,
  output logic [2*WIDTH-1:0] prodQ
);

  localparam int PW = 2 * WIDTH;

  initial begin
    a_param_width: assert (vcMulPkg::widthOk(WIDTH))
      else $error("WIDTH %0d is not a power of two in range", WIDTH);
  end

  vcMulNode #(.W(WIDTH), .KIND(ADD_KIND)) u_core (
    .a(opA),
    .b(opB),
    .p(prod)
  );

  // Capture register used to close timing around the combinational core
  always_ff @(posedge clk) begin
    if (!rstN) prodQ <= '0;
    else       prodQ <= prod;
  end

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      a_r1_exact: assert (prod == (PW'(opA) * PW'(opB)))
        else $error("product mismatch a=%0h b=%0h p=%0h", opA, opB, prod);
    end
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> prodQ == (PW'($past(opA)) * PW'($past(opB))))
    else $error("registered product does not match previous operands");

endmodule

// File: tb/vcMul_tb.sv
`timescale 1ns/100ps
module vcMul_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0]  a8, b8;
  logic [3:0]  a4, b4;
  logic [1:0]  a2, b2;
  logic [15:0] a16, b16;

  logic [15:0] p8, q8, p8p, q8p;
  logic [7:0]  p4, q4;
  logic [3:0]  p2, q2;
  logic [31:0] p16, q16;

  vcMul #(.WIDTH(8), .ADD_KIND(vcMulPkg::ADD3_CSA)) u_dut (
    .clk(clk), .rstN(rstN), .opA(a8), .opB(b8), .prod(p8), .prodQ(q8)
  );
  vcMul #(.WIDTH(8), .ADD_KIND(vcMulPkg::ADD3_PLAIN)) u_w8p (
    .clk(clk), .rstN(rstN), .opA(a8), .opB(b8), .prod(p8p), .prodQ(q8p)
  );
  vcMul #(.WIDTH(4)) u_w4 (
    .clk(clk), .rstN(rstN), .opA(a4), .opB(b4), .prod(p4), .prodQ(q4)
  );
  vcMul #(.WIDTH(2)) u_w2 (
    .clk(clk), .rstN(rstN), .opA(a2), .opB(b2), .prod(p2), .prodQ(q2)
  );
  vcMul #(.WIDTH(16)) u_w16 (
    .clk(clk), .rstN(rstN), .opA(a16), .opB(b16), .prod(p16), .prodQ(q16)
  );

  // Scoreboard queue of expected registered products for u_dut
  logic [15:0] expQ[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: applies operands after a falling edge, queues the registered
  // expectation and checks the combinational outputs before the next rise
  task automatic drive(input logic [7:0] x8, input logic [7:0] y8,
                       input logic [15:0] x16, input logic [15:0] y16,
                       input string tag16);
    logic [15:0] e8;
    @(negedge clk);
    #1;
    a8  = x8;       b8 = y8;
    a4  = x8[3:0];  b4 = y8[3:0];
    a2  = x8[1:0];  b2 = y8[1:0];
    a16 = x16;      b16 = y16;
    e8  = {8'h00, x8} * {8'h00, y8};
    expQ.push_back(e8);
    #1;
    check("R2 comb w8", {16'h0, p8}, {16'h0, e8});
    check("R6 plain-adder w8", {16'h0, p8p}, {16'h0, e8});
    check("R1 w4", {24'h0, p4}, {24'h0, {4'h0, x8[3:0]} * {4'h0, y8[3:0]}});
    check("R5 leaf w2", {28'h0, p2}, {28'h0, {2'b00, x8[1:0]} * {2'b00, y8[1:0]}});
    check(tag16, p16, {16'h0, x16} * {16'h0, y16});
  endtask

  // Monitor: at each falling edge pop the item captured at the prior rise
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [15:0] e;
      e = expQ.pop_front();
      check("R3 registered w8", {16'h0, q8}, {16'h0, e});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    a8 = 8'hA5; b8 = 8'h3C; a4 = 4'h9; b4 = 4'h7;
    a2 = 2'h3;  b2 = 2'h3;  a16 = 16'hFFFF; b16 = 16'h1234;
    repeat (3) @(negedge clk);
    // R4: reset clears the capture register despite nonzero operands
    check("R4 reset w8", {16'h0, q8}, 32'h0);
    check("R4 reset w16", q16, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R7 / R8 corners at full width
    drive(8'h00, 8'hFF, 16'h0000, 16'hFFFF, "R7 zero w16");
    drive(8'h01, 8'hC3, 16'h0001, 16'hBEEF, "R7 one w16");
    drive(8'hC3, 8'h01, 16'hBEEF, 16'h0001, "R7 one swapped w16");
    drive(8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, "R8 max w16");
    check("R8 max literal w16", p16, 32'hFFFE_0001);
    check("R8 max literal w8", {16'h0, p8}, 32'h0000_FE01);
    drive(8'hFF, 8'h00, 16'hFFFF, 16'h0001, "R7 max-by-one w16");

    // Exhaustive sweep at widths 8, 4 and 2; random operands at width 16
    for (int i = 0; i < 65536; i++) begin
      drive(i[7:0], i[15:8], 16'($urandom), 16'($urandom), "R1 random w16");
    end

    repeat (3) @(negedge clk);
    check("R3 queue drained", {31'h0, expQ.size() == 0}, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule